// File: doc/BRIEF.md
# Pin-Mask Serial Byte Loader

This block pushes bytes out bit by bit on a few pins of a general-purpose output port. It is meant for feeding a configuration stream into a programmable device. A configuration word names the port pins that carry the serial clock and those that carry data, and whether each byte leaves highest bit first or lowest bit first. The block does not own the port register. It reads the current register value, merges in its clock and data changes, and issues a write strobe. Every pin outside the two masks therefore keeps whatever value the register holds.

A configuration is accepted only if each mask overlaps both the port's writable pins (a parameter) and the pins that the direction input marks as outputs. Bytes arrive on a valid/ready handshake. Each byte becomes eight bits, and each bit takes three port writes: clock low, data set, clock high. A programmable divider stretches every phase so that data setup and clock high/low times can be met at any system clock rate. A byte offered while no valid configuration is held is consumed and refused, and the port is left untouched.

Top module: `pin_shift_loader`

## Requirements
- R1: Configuration word layout: bits 7:0 are the clock pin mask, bits 15:8 the data pin mask, and bit 16 selects highest-bit-first when 1. An accepted configuration write sets `cfg_ok` high and `cfg_err` low from the next cycle.
- R2: A configuration write is rejected unless the clock mask and the data mask each share at least one pin with the writable pins and at least one pin with `dir_oe` (1 = output). On rejection both stored masks become zero, `cfg_ok` goes low and `cfg_err` goes high, and any earlier good configuration is lost.
- R3: A byte offered while `cfg_ok` is low is taken (`byte_ready` is high). `perm_err` pulses high for exactly the next cycle. `busy` stays low and no port write is issued.
- R4: Each bit issues three writes in this order: clock pins cleared; data pins set to the bit value (all 1 or all 0); clock pins set.
- R5: A byte produces exactly 24 writes. The bit order is bit 7 down to bit 0 when the order select is 1, and bit 0 up to bit 7 when it is 0.
- R6: In every write, the pins outside the clock and data masks equal the port register value that was read in the cycle the write was formed.
- R7: The first write strobe comes in the cycle after the byte is accepted. Successive writes are exactly max(`phase_div`, 2) cycles apart, with `phase_div` sampled at acceptance.
- R8: `busy` is high and `byte_ready` low for exactly 24 × max(`phase_div`, 2) cycles per byte, starting the cycle after acceptance.
- R9: After a byte's last bit, the clock pins remain high and no write is issued until the next byte is accepted.
- R10: A configuration write while `busy` is high is ignored. The stored configuration, `cfg_ok` and `cfg_err` keep their values.
- R11: After reset, `byte_ready` is 1 and `busy`, `cfg_ok`, `cfg_err`, `perm_err` and `port_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 17 | Configuration word (data mask, clock mask, order select) |
| dir_oe | input | PORT_W | Port direction register, 1 = output |
| cfg_ok | output | 1 | A valid configuration is held |
| cfg_err | output | 1 | The last configuration write was rejected |
| phase_div | input | DIV_W | Minimum system clocks per phase |
| byte_valid | input | 1 | Byte offered |
| byte_data | input | 8 | Byte to serialise |
| byte_ready | output | 1 | Block can take a byte |
| busy | output | 1 | A byte is being shifted |
| perm_err | output | 1 | One-cycle pulse: byte refused for lack of configuration |
| port_q | input | PORT_W | Current value of the port output register |
| port_we | output | 1 | Port output register write strobe |
| port_d | output | PORT_W | Value to write into the port output register |

## Verification
The bench builds the block with an 18-pin port, a 4-bit divider and a writable mask in which pins 6 and 7 are read-only. This allows configurations to be rejected both for touching only non-writable pins and for touching only input pins, and allows a mask that only partly overlaps to still be accepted. With the narrow divider, the bench can run both the two-cycle floor (divider 0) and longer phases within one short run. An 18-bit register lets background values be placed on pins well above the low byte, where the read-modify-write merge has to preserve them.

// File: rtl/pin_shift_pkg.sv
package pin_shift_pkg;

   localparam int MASK_W = 8;
   localparam int CFG_W  = 2 * MASK_W + 1;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_DATA = 2'd2,
      PH_HIGH = 2'd3
   } phase_e;

   // packed so that a raw configuration word casts straight onto it
   typedef struct packed {
      logic              msb_first;
      logic [MASK_W-1:0] data_m;
      logic [MASK_W-1:0] clk_m;
   } shift_cfg_t;

endpackage

// File: rtl/pin_shift_cfg_guard.sv
module pin_shift_cfg_guard
   import pin_shift_pkg::*;
#(
   parameter int               PORT_W   = 18,
   parameter logic [PORT_W-1:0] WRITABLE = '1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_wr,
   input  logic [CFG_W-1:0]        cfg_word,
   input  logic [PORT_W-1:0]       dir_oe,
   input  logic                    hold,
   output shift_cfg_t              cfg_q,
   output logic                    cfg_ok,
   output logic                    cfg_err
);

   shift_cfg_t        req;
   logic [PORT_W-1:0] req_clk, req_dat;
   logic              req_good;

   always_comb begin
      req      = shift_cfg_t'(cfg_word);
      req_clk  = PORT_W'(req.clk_m);
      req_dat  = PORT_W'(req.data_m);
      req_good = (|(req_clk & WRITABLE)) && (|(req_dat & WRITABLE)) &&
                 (|(req_clk & dir_oe))   && (|(req_dat & dir_oe));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         cfg_err <= 1'b0;
      end else if (cfg_wr && !hold) begin
         cfg_q   <= req_good ? req : '0;
         cfg_err <= !req_good;
      end
   end

   assign cfg_ok = (|cfg_q.clk_m) && (|cfg_q.data_m);

endmodule

// File: rtl/pin_shift_pacer.sv
module pin_shift_pacer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             advance,
   input  logic [DIV_W-1:0] div_in,
   output logic             expire
);

   localparam logic [DIV_W-1:0] FLOOR = DIV_W'(2);

   logic [DIV_W-1:0] len_q, cnt_q, eff_len, load_len;

   always_comb begin
      eff_len  = (div_in < FLOOR) ? FLOOR : div_in;
      load_len = start ? eff_len : len_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= FLOOR;
         cnt_q <= '0;
      end else begin
         if (start) len_q <= eff_len;
         if (start || advance)  cnt_q <= load_len - 1'b1;
         else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = (cnt_q == '0);

endmodule

// File: rtl/pin_shift_seq.sv
module pin_shift_seq
   import pin_shift_pkg::*;
#(
   parameter int PORT_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   input  logic              msb_first,
   input  logic              cfg_ok,
   input  logic [PORT_W-1:0] clk_full,
   input  logic [PORT_W-1:0] dat_full,
   input  logic [PORT_W-1:0] port_q,
   input  logic              expire,
   output logic              byte_ready,
   output logic              busy,
   output logic              perm_err,
   output logic              start,
   output logic              advance,
   output logic              port_we,
   output logic [PORT_W-1:0] port_d
);

   phase_e     ph_q;
   logic [7:0] shreg_q;
   logic [2:0] bit_q;
   logic       take, cur_bit;

   always_comb begin
      byte_ready = (ph_q == PH_IDLE);
      busy       = !byte_ready;
      take       = byte_valid && byte_ready;
      start      = take && cfg_ok;
      advance    = busy && expire;
      cur_bit    = msb_first ? shreg_q[7] : shreg_q[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         shreg_q  <= '0;
         bit_q    <= '0;
         port_we  <= 1'b0;
         port_d   <= '0;
         perm_err <= 1'b0;
      end else begin
         port_we  <= 1'b0;
         perm_err <= take && !cfg_ok;
         if (start) begin
            ph_q    <= PH_LOW;
            shreg_q <= byte_data;
            bit_q   <= '0;
            port_we <= 1'b1;
            port_d  <= port_q & ~clk_full;
         end else if (advance) begin
            unique case (ph_q)
               PH_LOW: begin
                  ph_q    <= PH_DATA;
                  port_we <= 1'b1;
                  port_d  <= (port_q & ~dat_full) | (cur_bit ? dat_full : '0);
               end
               PH_DATA: begin
                  ph_q    <= PH_HIGH;
                  port_we <= 1'b1;
                  port_d  <= port_q | clk_full;
               end
               PH_HIGH: begin
                  if (bit_q == 3'd7) begin
                     ph_q <= PH_IDLE;
                  end else begin
                     ph_q    <= PH_LOW;
                     bit_q   <= bit_q + 3'd1;
                     shreg_q <= msb_first ? {shreg_q[6:0], 1'b0} : {1'b0, shreg_q[7:1]};
                     port_we <= 1'b1;
                     port_d  <= port_q & ~clk_full;
                  end
               end
               default: ph_q <= PH_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/pin_shift_loader.sv
module pin_shift_loader
   import pin_shift_pkg::*;
#(
   parameter int                PORT_W   = 18,
   parameter int                DIV_W    = 8,
   parameter logic [PORT_W-1:0] WRITABLE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [16:0]       cfg_word,
   input  logic [PORT_W-1:0] dir_oe,
   output logic              cfg_ok,
   output logic              cfg_err,
   input  logic [DIV_W-1:0]  phase_div,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   output logic              byte_ready,
   output logic              busy,
   output logic              perm_err,
   input  logic [PORT_W-1:0] port_q,
   output logic              port_we,
   output logic [PORT_W-1:0] port_d
);

   localparam int PAD_W = PORT_W - MASK_W;

   if (PORT_W < MASK_W) begin : g_bad_port
      $error("PORT_W must cover the 8-bit pin masks");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must hold the two-cycle phase floor");
   end

   shift_cfg_t        cfg_q;
   logic [PORT_W-1:0] clk_full, dat_full;
   logic              start, advance, expire;

   if (PAD_W > 0) begin : g_pad
      assign clk_full = {{PAD_W{1'b0}}, cfg_q.clk_m};
      assign dat_full = {{PAD_W{1'b0}}, cfg_q.data_m};
   end else begin : g_nopad
      assign clk_full = cfg_q.clk_m;
      assign dat_full = cfg_q.data_m;
   end

   pin_shift_cfg_guard #(.PORT_W(PORT_W), .WRITABLE(WRITABLE)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_word (cfg_word),
      .dir_oe   (dir_oe),
      .hold     (busy),
      .cfg_q    (cfg_q),
      .cfg_ok   (cfg_ok),
      .cfg_err  (cfg_err)
   );

   pin_shift_pacer #(.DIV_W(DIV_W)) u_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .advance (advance),
      .div_in  (phase_div),
      .expire  (expire)
   );

   pin_shift_seq #(.PORT_W(PORT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .msb_first  (cfg_q.msb_first),
      .cfg_ok     (cfg_ok),
      .clk_full   (clk_full),
      .dat_full   (dat_full),
      .port_q     (port_q),
      .expire     (expire),
      .byte_ready (byte_ready),
      .busy       (busy),
      .perm_err   (perm_err),
      .start      (start),
      .advance    (advance),
      .port_we    (port_we),
      .port_d     (port_d)
   );

endmodule

// File: rtl/pin_shift_loader_chk.sv
module pin_shift_loader_chk #(
   parameter int PORT_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              byte_valid,
   input logic              byte_ready,
   input logic              busy,
   input logic              cfg_ok,
   input logic              cfg_err,
   input logic              perm_err,
   input logic              port_we,
   input logic [PORT_W-1:0] port_q,
   input logic [PORT_W-1:0] port_d,
   input logic [15:0]       mask_pair
);

   logic [PORT_W-1:0] keep_m;
   assign keep_m = ~(PORT_W'(mask_pair[7:0]) | PORT_W'(mask_pair[15:8]));

   assert_reject_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !cfg_ok);

   assert_refused_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && byte_ready && !cfg_ok) |=> (perm_err && !busy));

   assert_refusal_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      perm_err |-> !port_we);

   assert_merge_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      port_we |-> (((port_d ^ $past(port_q)) & keep_m) == '0));

   assert_first_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && byte_ready && cfg_ok) |=> (busy && port_we));

   assert_write_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      port_we |=> !port_we);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !port_we);

endmodule

bind pin_shift_loader pin_shift_loader_chk #(.PORT_W(PORT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_valid (byte_valid),
   .byte_ready (byte_ready),
   .busy       (busy),
   .cfg_ok     (cfg_ok),
   .cfg_err    (cfg_err),
   .perm_err   (perm_err),
   .port_we    (port_we),
   .port_q     (port_q),
   .port_d     (port_d),
   .mask_pair  (cfg_q[15:0])
);

// File: tb/pin_shift_loader_bench.sv
`timescale 1ns/1ps
module pin_shift_loader_bench;

   localparam int                PW  = 18;
   localparam int                DW  = 4;
   localparam logic [PW-1:0]     WRT = 18'h3FF3F;

   typedef struct {
      int          kind;
      bit          b;
      logic [PW-1:0] cm;
      logic [PW-1:0] dm;
      int          n;
      bit          first;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [16:0]   cfg_word = '0;
   logic [PW-1:0] dir_oe = 18'h0000F;
   logic          cfg_ok, cfg_err, byte_ready, busy, perm_err, port_we;
   logic [DW-1:0] phase_div = '0;
   logic          byte_valid = 1'b0;
   logic [7:0]    byte_data = '0;
   logic [PW-1:0] port_reg, port_d;
   logic          bg_we = 1'b0;
   logic [PW-1:0] bg_val = '0;

   int   checks = 0, fails = 0, cyc = 0, last_we = 0;
   bit   done = 0;
   exp_t q[$];

   always #4 clk = ~clk;

   pin_shift_loader #(.PORT_W(PW), .DIV_W(DW), .WRITABLE(WRT)) u_pin_shift_loader (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word), .dir_oe(dir_oe),
      .cfg_ok(cfg_ok), .cfg_err(cfg_err), .phase_div(phase_div),
      .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
      .busy(busy), .perm_err(perm_err), .port_q(port_reg), .port_we(port_we), .port_d(port_d)
   );

   // port output register model shared with a background writer
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n)        port_reg <= 18'h00000;
      else if (port_we)  port_reg <= port_d;
      else if (bg_we)    port_reg <= bg_val;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // monitor: pops one expected write per strobe
   always @(negedge clk) begin
      if (rst_n && port_we) begin
         if (q.size() == 0) begin
            chk(1'b0, "R9 write while idle", 32'(port_d), 32'(port_reg));
         end else begin
            exp_t e;
            logic [PW-1:0] ex;
            e = q.pop_front();
            case (e.kind)
               0:       ex = port_reg & ~e.cm;
               1:       ex = (port_reg & ~e.dm) | (e.b ? e.dm : '0);
               default: ex = port_reg | e.cm;
            endcase
            chk(port_d == ex, "R4/R5/R6 write value", 32'(port_d), 32'(ex));
            if (!e.first) chk((cyc - last_we) == e.n, "R7 write spacing", 32'(cyc - last_we), 32'(e.n));
            last_we = cyc;
         end
      end
   end

   task automatic write_cfg(input bit msb, input logic [7:0] dm, input logic [7:0] cm);
      cfg_word = {msb, dm, cm};
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic set_bg(input logic [PW-1:0] v);
      bg_val = v; bg_we = 1'b1;
      @(negedge clk);
      bg_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit msb, input logic [7:0] cm,
                            input logic [7:0] dm, input int div, input bit inject);
      int   n, cnt;
      bit   lastb;
      n = (div < 2) ? 2 : div;
      for (int i = 0; i < 8; i++) begin
         int idx;
         bit bv;
         idx = msb ? 7 - i : i;
         bv  = b[idx];
         lastb = bv;
         q.push_back('{0, 1'b0, PW'(cm), PW'(dm), n, i == 0});
         q.push_back('{1, bv,   PW'(cm), PW'(dm), n, 1'b0});
         q.push_back('{2, 1'b0, PW'(cm), PW'(dm), n, 1'b0});
      end
      phase_div = DW'(div); byte_data = b; byte_valid = 1'b1;
      @(negedge clk);
      byte_valid = 1'b0;
      chk(busy && port_we, "R7 first write after accept", {30'd0, busy, port_we}, 32'd3);
      cnt = 0;
      while (busy) begin
         if (byte_ready) chk(1'b0, "R8 ready while busy", 32'd1, 32'd0);
         cnt++;
         if (inject && cnt == 3) begin cfg_word = {1'b1, 8'h00, 8'hC0}; cfg_wr = 1'b1; end
         if (inject && cnt == 4) cfg_wr = 1'b0;
         @(negedge clk);
      end
      chk(cnt == 24 * n, "R8 busy length", 32'(cnt), 32'(24 * n));
      chk(q.size() == 0, "R5 24 writes per byte", 32'(q.size()), 32'd0);
      chk((port_reg & PW'(cm)) == PW'(cm), "R9 clock left high", 32'(port_reg & PW'(cm)), 32'(cm));
      chk((port_reg & PW'(dm)) == (lastb ? PW'(dm) : '0), "R4 final data level",
          32'(port_reg & PW'(dm)), 32'(lastb ? dm : 8'h00));
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(byte_ready && !busy && !cfg_ok && !cfg_err && !perm_err && !port_we, "R11 reset outputs",
          {26'd0, byte_ready, busy, cfg_ok, cfg_err, perm_err, port_we}, 32'h20);

      // R3 refusal with no configuration yet
      byte_data = 8'h55; byte_valid = 1'b1;
      @(negedge clk);
      byte_valid = 1'b0;
      chk(perm_err && !busy && !port_we, "R3 refused byte pulse", {29'd0, perm_err, busy, port_we}, 32'h4);
      @(negedge clk);
      chk(!perm_err, "R3 pulse one cycle", 32'(perm_err), 32'd0);

      // R1 accept, msb first: clock pin0, data pin1
      write_cfg(1'b1, 8'h02, 8'h01);
      chk(cfg_ok && !cfg_err, "R1 accepted config", {30'd0, cfg_ok, cfg_err}, 32'h2);
      set_bg(18'h2A5F0);
      send_byte(8'hA5, 1'b1, 8'h01, 8'h02, 0, 1'b0);

      // R5 lsb first, longer phases, different background
      write_cfg(1'b0, 8'h02, 8'h01);
      set_bg(18'h15A0C);
      send_byte(8'h3C, 1'b0, 8'h01, 8'h02, 5, 1'b0);

      // R2 partial overlap still accepted; multi-pin data mask
      write_cfg(1'b0, 8'h06, 8'h81);
      chk(cfg_ok && !cfg_err, "R2 partial overlap accepted", {30'd0, cfg_ok, cfg_err}, 32'h2);
      set_bg(18'h3FF70);
      send_byte(8'h01, 1'b0, 8'h81, 8'h06, 3, 1'b0);

      // R10 config write during a byte is ignored
      send_byte(8'h96, 1'b0, 8'h81, 8'h06, 2, 1'b1);
      chk(cfg_ok && !cfg_err, "R10 config kept", {30'd0, cfg_ok, cfg_err}, 32'h2);
      send_byte(8'hFF, 1'b0, 8'h81, 8'h06, 1, 1'b0);

      // R2 reject: clock mask only on read-only pins
      write_cfg(1'b1, 8'h02, 8'hC0);
      chk(!cfg_ok && cfg_err, "R2 non-writable clock rejected", {30'd0, cfg_ok, cfg_err}, 32'h1);
      byte_data = 8'h12; byte_valid = 1'b1;
      @(negedge clk);
      byte_valid = 1'b0;
      chk(perm_err && !busy, "R3 refused after reject", {30'd0, perm_err, busy}, 32'h2);
      repeat (4) @(negedge clk);

      // R2 reject: data mask only on input pins
      write_cfg(1'b1, 8'h01, 8'h10);
      write_cfg(1'b1, 8'h10, 8'h01);
      chk(!cfg_ok && cfg_err, "R2 input data pin rejected", {30'd0, cfg_ok, cfg_err}, 32'h1);
      write_cfg(1'b1, 8'h08, 8'h04);
      chk(cfg_ok && !cfg_err, "R1 reaccepted", {30'd0, cfg_ok, cfg_err}, 32'h2);
      send_byte(8'h6B, 1'b1, 8'h04, 8'h08, 4, 1'b0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule